// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block collects interrupt requests from five sources of a small CPU core: two active-low external pins, two timer overflow events and one combined serial receive/transmit flag. It keeps the pending flags, an enable register with a master gate and a priority register with one bit per source. From these it chooses one request and offers it to the core as a 16-bit vector address.

The offer uses a valid/ready handshake. `irq_valid` is high whenever some enabled request may interrupt the handler currently running. The handshake completes on a rising clock edge where both `irq_valid` and `irq_ready` are high. That edge marks the request as in service at its level and clears the flag where hardware clearing applies. The offer is not held while `irq_ready` is low. The choice is made again every cycle, so a request that becomes more urgent replaces the one on offer, and a request whose flag drops is withdrawn. The core signals the end of a handler with a one-cycle `ret_pulse`.

Two levels of nesting are supported. A low-level handler can be interrupted only by a high-level request, and a high-level handler cannot be interrupted. The timer and serial logic, the stack and the CPU itself sit outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source indices are 0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = timer 1, 4 = serial. The vector for source i is 0x0003 + 8*i, which gives 0003, 000B, 0013, 001B and 0023. Among requests at the same level, the lowest index wins.
- R2: A pending, enabled high-level request (priority bit 1) wins over any low-level request, whatever their indices.
- R3: While a low-level handler is in service, only high-level requests are offered. While a high-level handler is in service, nothing is offered.
- R4: `ret_pulse` clears the highest set in-service bit. `in_svc` bit 1 is the high level and bit 0 is the low level.
- R5: An external pin in edge mode (`ext_edge_mode` bit = 1) passes through a two-flop synchronizer. Its flag is set when one synchronized sample is high and the next is low, within four clocks of the pin falling. A pin held low does not set the flag again.
- R6: An external pin in level mode (`ext_edge_mode` bit = 0) has a flag that follows the synchronized low level of the pin. Neither a handshake nor `flag_clr` clears it.
- R7: A completed handshake clears the flag of a timer source, or of an external source in edge mode, on the same edge. The serial flag is a direct copy of `ser_flag` and is never cleared here.
- R8: `ie_wdata` bit i enables source i and bit 5 is the master gate. A request is offered only when both its enable bit and the master gate are 1. A disabled flag stays pending.
- R9: A `flag_clr` bit clears the flag of a timer source, or of an edge-mode external source, with the same index. A setting event in the same cycle takes precedence and leaves the flag set.
- R10: While `irq_ready` is low, the offer stays up as long as an eligible request exists, and the vector follows the current arbitration result.
- R11: After reset all flags, enables, priorities and in-service bits are 0 and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | Asynchronous active-low external request pins |
| ext_edge_mode | input | 2 | Trigger mode per pin: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | One-cycle overflow events from timer 0 and timer 1 |
| ser_flag | input | 1 | Combined serial receive/transmit flag (level) |
| flag_clr | input | 4 | Software clear for the flags of sources 0 to 3 |
| ie_wr | input | 1 | Write strobe for the enable register |
| ie_wdata | input | 6 | Enable value: bits 4..0 per source, bit 5 master gate |
| ip_wr | input | 1 | Write strobe for the priority register |
| ip_wdata | input | 5 | Priority value, 1 = high level |
| irq_ready | input | 1 | Core accepts the offered vector |
| ret_pulse | input | 1 | One-cycle end-of-handler indication |
| irq_valid | output | 1 | A vector is offered |
| irq_vector | output | 16 | Handler address of the offered source |
| pend_flags | output | 5 | Current flags, indexed as in R1 |
| in_svc | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
The hardest state to reach is a full two-level nesting where both in-service bits are set and a further high-level request is already pending. Only in that state can the bench show that nothing is offered, and that the first return exposes the waiting high-level request before the low handler resumes. The stimulus gets there by accepting a low-level timer request and then raising a timer that was made high-level. It accepts that request as well and then pulses the same timer again. The withdrawal and replacement of an offer under back-pressure is also exercised. The bench holds `irq_ready` low while an external edge arrives behind a pending timer request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 5;
  localparam int NPAIR    = 2;
  localparam int IDX_W    = 3;
  localparam int VEC_W    = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
  localparam int VEC_STEP = 8;
  localparam int SER_IDX  = 4;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic is_low,
  output logic fell
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign is_low = ~sync_q[STAGES-1];
  assign fell   = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] edge_mode,
  input  logic [NPAIR-1:0] ext_fell,
  input  logic [NPAIR-1:0] ext_low,
  input  logic [NPAIR-1:0] tmr_set,
  input  logic             ser_in,
  input  logic [NSRC-2:0]  sw_clr,
  input  logic [NSRC-1:0]  hw_clr,
  output logic [NSRC-1:0]  flags
);
  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    localparam int EI = 2*j;
    localparam int TI = 2*j + 1;
    logic ext_q, tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ext_q <= 1'b0;
      end else if (!edge_mode[j]) begin
        ext_q <= ext_low[j];
      end else if (ext_fell[j]) begin
        ext_q <= 1'b1;
      end else if (sw_clr[EI] || hw_clr[EI]) begin
        ext_q <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr_q <= 1'b0;
      end else if (tmr_set[j]) begin
        tmr_q <= 1'b1;
      end else if (sw_clr[TI] || hw_clr[TI]) begin
        tmr_q <= 1'b0;
      end
    end

    assign flags[EI] = ext_q;
    assign flags[TI] = tmr_q;

    // R7
    tmr_hwclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr[TI] && !tmr_set[j]) |=> !flags[TI]);

    // R6
    lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode[j] && ext_low[j] && hw_clr[EI]) |=> flags[EI]);
  end

  assign flags[SER_IDX] = ser_in;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  hi_sel,
  input  logic [1:0]       busy,
  output logic             any,
  output logic             pick_hi,
  output logic [NSRC-1:0]  grant,
  output logic [IDX_W-1:0] idx
);
  logic [NSRC-1:0] hi_req, lo_req, hi_oh, lo_oh;
  logic            hi_ok, lo_ok;

  assign hi_req = req & hi_sel;
  assign lo_req = req & ~hi_sel;
  assign hi_oh  = hi_req & (~hi_req + 1'b1);
  assign lo_oh  = lo_req & (~lo_req + 1'b1);
  assign hi_ok  = (|hi_req) && !busy[1];
  assign lo_ok  = (|lo_req) && (busy == 2'b00);

  assign pick_hi = hi_ok;
  assign any     = hi_ok || lo_ok;
  assign grant   = hi_ok ? hi_oh : (lo_ok ? lo_oh : '0);

  always_comb begin
    idx = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_pin_n,
  input  logic [1:0]       ext_edge_mode,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_flag,
  input  logic [3:0]       flag_clr,
  input  logic             ie_wr,
  input  logic [5:0]       ie_wdata,
  input  logic             ip_wr,
  input  logic [4:0]       ip_wdata,
  input  logic             irq_ready,
  input  logic             ret_pulse,
  output logic             irq_valid,
  output logic [15:0]      irq_vector,
  output logic [4:0]       pend_flags,
  output logic [1:0]       in_svc
);
  logic [NPAIR-1:0] ext_low, ext_fell;
  logic [NSRC-1:0]  flags, req, grant, hw_clr;
  logic [NSRC:0]    ie_q;
  logic [NSRC-1:0]  ip_q;
  logic [1:0]       isr_q, isr_after_ret;
  logic             any, pick_hi, ack;
  logic [IDX_W-1:0] idx;

  for (genvar j = 0; j < NPAIR; j++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[j]),
      .is_low(ext_low[j]), .fell(ext_fell[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      ip_q <= '0;
    end else begin
      if (ie_wr) ie_q <= ie_wdata;
      if (ip_wr) ip_q <= ip_wdata;
    end
  end

  assign ack    = irq_valid && irq_ready;
  assign hw_clr = ack ? grant : '0;

  irq_flag_bank bank_i (
    .clk(clk), .rst_n(rst_n), .edge_mode(ext_edge_mode),
    .ext_fell(ext_fell), .ext_low(ext_low), .tmr_set(tmr_ovf),
    .ser_in(ser_flag), .sw_clr(flag_clr), .hw_clr(hw_clr), .flags(flags)
  );

  assign req = ie_q[NSRC] ? (flags & ie_q[NSRC-1:0]) : '0;

  irq_prio_pick pick_i (
    .req(req), .hi_sel(ip_q), .busy(isr_q),
    .any(any), .pick_hi(pick_hi), .grant(grant), .idx(idx)
  );

  always_comb begin
    isr_after_ret = isr_q;
    if (ret_pulse) begin
      if (isr_q[1]) isr_after_ret[1] = 1'b0;
      else          isr_after_ret[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= 2'b00;
    end else begin
      isr_q <= isr_after_ret;
      if (ack) isr_q[pick_hi] <= 1'b1;
    end
  end

  assign irq_valid  = any;
  assign irq_vector = vec_of(idx);
  assign pend_flags = flags;
  assign in_svc     = isr_q;

  // R3
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[1] |-> !irq_valid);

  // R3
  lo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q[0] && irq_valid) |-> (|(grant & ip_q)));

  // R4
  ret_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pulse && isr_q == 2'b11) |=> (isr_q == 2'b01));

  // R4
  ret_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pulse && isr_q == 2'b01 && !ack) |=> (isr_q == 2'b00));

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($onehot0(grant) && (grant & flags) == grant));

  // R8
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ie_q[NSRC]);
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b11;
  logic [1:0] ext_edge_mode = 2'b11;
  logic [1:0] tmr_ovf = 2'b00;
  logic ser_flag = 1'b0;
  logic [3:0] flag_clr = 4'h0;
  logic ie_wr = 1'b0;
  logic [5:0] ie_wdata = 6'h0;
  logic ip_wr = 1'b0;
  logic [4:0] ip_wdata = 5'h0;
  logic irq_ready = 1'b0;
  logic ret_pulse = 1'b0;
  logic irq_valid;
  logic [15:0] irq_vector;
  logic [4:0] pend_flags;
  logic [1:0] in_svc;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irq_vec_ctrl dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compares each completed handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected handshake actual=%0h expected=none", irq_vector);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (irq_vector != e) begin
          failures++;
          $display("FAIL %s vector actual=%0h expected=%0h", t, irq_vector, e);
        end
      end
    end
  end

  task automatic take(input string tag, input logic [15:0] exp);
    int n = 0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    while (!irq_valid && n < 20) begin
      step(1);
      n++;
    end
    if (!irq_valid) begin
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
      chk({tag, " no offer"}, 0, 1);
    end else begin
      irq_ready = 1'b1;
      step(1);
      irq_ready = 1'b0;
    end
  endtask

  task automatic ret();
    ret_pulse = 1'b1;
    step(1);
    ret_pulse = 1'b0;
  endtask

  task automatic tpulse(input logic [1:0] m);
    tmr_ovf = m;
    step(1);
    tmr_ovf = 2'b00;
  endtask

  task automatic wr_ie(input logic [5:0] v);
    ie_wdata = v; ie_wr = 1'b1; step(1); ie_wr = 1'b0;
  endtask

  task automatic wr_ip(input logic [4:0] v);
    ip_wdata = v; ip_wr = 1'b1; step(1); ip_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    chk("R11 valid", irq_valid, 0);
    chk("R11 flags", pend_flags, 0);
    chk("R11 in_svc", in_svc, 0);

    wr_ie(6'h3F);
    wr_ip(5'h00);

    // R1 polling order, R5 edge, R7 hardware clear
    tmr_ovf = 2'b11; ext_pin_n[1] = 1'b0;
    step(1); tmr_ovf = 2'b00;
    step(4);
    chk("R5 edge flag set", pend_flags, 5'b01110);
    take("R1 timer0 first", 16'h000B);
    chk("R7 timer flag cleared", pend_flags, 5'b01100);
    chk("R3 low blocks low", irq_valid, 0);
    chk("R3 in_svc low", in_svc, 2'b01);
    ret();
    chk("R4 low return", in_svc, 2'b00);
    take("R1 ext1 second", 16'h0013);
    chk("R7 edge flag cleared", pend_flags, 5'b01000);
    ret();
    step(4);
    chk("R5 held low no retrigger", pend_flags[2], 0);
    take("R1 timer1 third", 16'h001B);
    ret();
    ext_pin_n[1] = 1'b1;
    step(4);
    chk("R1 idle", irq_valid, 0);

    // R3/R4 nesting: timer1 high level
    wr_ip(5'b01000);
    tpulse(2'b01);
    take("R3 low accepted", 16'h000B);
    tpulse(2'b01);
    chk("R3 low not preempt low", irq_valid, 0);
    tpulse(2'b10);
    take("R3 high preempts low", 16'h001B);
    chk("R3 nested", in_svc, 2'b11);
    tpulse(2'b10);
    chk("R3 high not preempted", irq_valid, 0);
    ret();
    chk("R4 high return", in_svc, 2'b01);
    take("R4 pending high after return", 16'h001B);
    ret();
    ret();
    chk("R4 both returned", in_svc, 2'b00);
    take("R4 low resumes", 16'h000B);
    ret();

    // R2 high beats lower index
    ext_pin_n[0] = 1'b0;
    tpulse(2'b10);
    step(4);
    take("R2 high wins", 16'h001B);
    ret();
    take("R2 low after", 16'h0003);
    ret();
    ext_pin_n[0] = 1'b1;
    wr_ip(5'h00);
    step(4);

    // R6 level mode
    ext_edge_mode[0] = 1'b0;
    ext_pin_n[0] = 1'b0;
    step(4);
    chk("R6 level flag", pend_flags[0], 1);
    take("R6 level vector", 16'h0003);
    chk("R6 not cleared by ack", pend_flags[0], 1);
    flag_clr = 4'b0001; step(1); flag_clr = 4'h0;
    chk("R6 not cleared by sw", pend_flags[0], 1);
    ret();
    take("R6 reoffered", 16'h0003);
    ret();
    ext_pin_n[0] = 1'b1;
    step(4);
    chk("R6 follows pin", pend_flags[0], 0);
    chk("R6 no offer", irq_valid, 0);
    ext_edge_mode[0] = 1'b1;

    // R8 enables
    wr_ie(6'h1F);
    tpulse(2'b01);
    chk("R8 master off", irq_valid, 0);
    chk("R8 flag kept", pend_flags[1], 1);
    wr_ie(6'h3D);
    chk("R8 source off", irq_valid, 0);
    wr_ie(6'h3F);
    take("R8 reenabled", 16'h000B);
    ret();

    // R9 software clear
    wr_ie(6'h1F);
    tpulse(2'b10);
    flag_clr = 4'b1000; step(1); flag_clr = 4'h0;
    chk("R9 sw clear", pend_flags[3], 0);
    tmr_ovf = 2'b10; flag_clr = 4'b1000; step(1);
    tmr_ovf = 2'b00; flag_clr = 4'h0;
    chk("R9 set wins", pend_flags[3], 1);
    flag_clr = 4'b1000; step(1); flag_clr = 4'h0;
    wr_ie(6'h3F);

    // R1/R7 serial
    ser_flag = 1'b1;
    step(1);
    take("R1 serial vector", 16'h0023);
    chk("R7 serial not cleared", pend_flags[4], 1);
    ret();
    ser_flag = 1'b0;
    step(1);
    chk("R7 serial follows input", irq_valid, 0);

    // R10 back-pressure re-arbitration
    tpulse(2'b01);
    step(3);
    chk("R10 offer held", irq_valid, 1);
    chk("R10 vector timer0", irq_vector, 16'h000B);
    ext_pin_n[0] = 1'b0;
    step(4);
    chk("R10 vector replaced", irq_vector, 16'h0003);
    take("R10 new winner", 16'h0003);
    ret();
    take("R10 old winner", 16'h000B);
    ret();
    ext_pin_n[0] = 1'b1;
    step(4);

    chk("scoreboard drained", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule